// File: doc/BRIEF.md
# BPSK Subcarrier Load Modulator

This block turns a serial stream of frame bits into a phase-reversal-keyed subcarrier that switches the antenna load of a contactless tag. It runs from a clock at the carrier rate and divides it by sixteen to form the subcarrier. Each data bit lasts a selectable whole number of subcarrier cycles. The subcarrier sits in a reference phase that stands for logic 1. It turns over by half a cycle whenever the bit value changes.

A frame transmitter raises the frame request and presents the first bit. The modulator first sends a lead-in of reference-phase subcarrier lasting a fixed number of bit periods. It then takes one bit per bit period and pulses a one-clock strobe each time it has taken a bit, so the upstream serializer can present the next one. When the request is low at a bit boundary, the modulator sends a tail of reference-phase subcarrier and then goes silent. The bit rate is captured once, when the frame starts.

Top module: `bpsk_load_mod`

## Requirements
- R1: After reset, and whenever no frame is in progress, load_drive and bit_tick are both 0. The reset value of the captured rate is the slowest setting.
- R2: While a frame is in progress the subcarrier period is 16 clocks. In the reference phase it is high for the first 8 clocks and low for the last 8. The first high clock is the one right after the clock edge that sees frame_req high while idle.
- R3: rate_sel sets the bit length in subcarrier cycles: 0 gives 8, 1 gives 4, 2 gives 2 and 3 gives 1. One bit period is therefore 16 times that many clocks.
- R4: A frame opens with LEAD_BITS bit periods of reference-phase subcarrier, and bit_tick stays 0 during that lead-in.
- R5: While a data bit is being sent, the subcarrier is in reference phase for bit value 1 and inverted for bit value 0. The phase therefore reverses only when consecutive bits differ. A phase change happens only where one subcarrier cycle ends and the next begins, so load_drive never holds a level for less than 2 clocks.
- R6: bit_in is sampled at the end of the lead-in and at each later bit boundary for as long as the frame continues. bit_tick is high for exactly the one clock that follows each such sample.
- R7: frame_req is examined at each bit boundary after the first data bit. If it is low, TAIL_BITS bit periods of reference-phase subcarrier follow, and then the block returns to idle.
- R8: Changes on rate_sel while a frame is in progress have no effect on that frame's bit length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_req | input | 1 | High while the frame transmitter has bits to send |
| bit_in | input | 1 | Serial data bit presented by the frame transmitter |
| rate_sel | input | 2 | Bit length select: 0=8, 1=4, 2=2, 3=1 subcarrier cycles |
| load_drive | output | 1 | Drive for the antenna load switch |
| bit_tick | output | 1 | One-clock strobe after each data bit is taken |

## Verification
The hardest situation to reach from the ports is a change on rate_sel in the middle of a frame, combined with a frame whose end lands on a bit boundary that follows a 0 bit. That combination forces both the rate capture and the tail phase reversal to act at once. The stimulus reacts to each bit_tick: it presents the next bit, or drops frame_req after the last one, in the same clock as the strobe. It also moves rate_sel to other values partway through selected frames. Directed frames cover all-ones data (no reversals), all-zeros data, alternating data and a single-bit frame at the fastest rate. Seeded random frames vary the rate, the length and the data.

// File: rtl/bpsk_pkg.sv
package bpsk_pkg;

    // Frame sequencing of the modulator
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_DATA = 2'd2,
        ST_TAIL = 2'd3
    } tx_state_e;

    // Rate code 0 is the slowest (power-up) bit length
    localparam logic [1:0] RATE_SLOWEST = 2'd0;

endpackage

// File: rtl/bpsk_sc_div.sv
// Subcarrier divider: free-runs while run is high, parked at zero otherwise.
module bpsk_sc_div #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sc_wave,
    output logic sc_last
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (cnt_q == LAST)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign sc_wave = (cnt_q < HALF);
    assign sc_last = run && (cnt_q == LAST);

endmodule

// File: rtl/bpsk_bit_timer.sv
// Counts subcarrier cycles inside one bit; bit length = SC_MAX >> rate.
module bpsk_bit_timer #(
    parameter int SC_MAX = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       sc_last,
    input  logic [1:0] rate,
    output logic       bit_end
);
    localparam int YW = $clog2(SC_MAX);

    logic [YW:0]   ncyc;
    logic [YW-1:0] cyc_d, cyc_q;
    logic          at_last;

    assign ncyc    = (YW+1)'(SC_MAX) >> rate;
    assign at_last = ({1'b0, cyc_q} == (ncyc - 1'b1));

    always_comb begin
        cyc_d = cyc_q;
        if (!run)
            cyc_d = '0;
        else if (sc_last)
            cyc_d = at_last ? '0 : cyc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_d;
    end

    assign bit_end = sc_last && at_last;

endmodule

// File: rtl/bpsk_load_mod.sv
module bpsk_load_mod
    import bpsk_pkg::*;
#(
    parameter int DIV       = 16,
    parameter int SC_MAX    = 8,
    parameter int LEAD_BITS = 2,
    parameter int TAIL_BITS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_req,
    input  logic       bit_in,
    input  logic [1:0] rate_sel,
    output logic       load_drive,
    output logic       bit_tick
);
    localparam int EDGE_MAX = (LEAD_BITS > TAIL_BITS) ? LEAD_BITS : TAIL_BITS;
    localparam int BW       = $clog2(EDGE_MAX + 1);
    localparam logic [BW-1:0] LEAD_LAST = BW'(LEAD_BITS - 1);
    localparam logic [BW-1:0] TAIL_LAST = BW'(TAIL_BITS - 1);

    typedef struct packed {
        tx_state_e     st;
        logic [1:0]    rate;      // captured at frame start
        logic [BW-1:0] bcnt;      // bit periods in lead-in / tail
        logic          phase;     // 0 = reference phase
        logic          last_bit;  // last value sent, 1 outside data
        logic          tick;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic run, sc_wave, sc_last, bit_end;

    assign run = (cur_q.st != ST_IDLE);

    bpsk_sc_div #(.DIV(DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .sc_wave (sc_wave),
        .sc_last (sc_last)
    );

    bpsk_bit_timer #(.SC_MAX(SC_MAX)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .sc_last (sc_last),
        .rate    (cur_q.rate),
        .bit_end (bit_end)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.tick = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (frame_req) begin
                    nxt_d.st       = ST_LEAD;
                    nxt_d.rate     = rate_sel;
                    nxt_d.bcnt     = '0;
                    nxt_d.phase    = 1'b0;
                    nxt_d.last_bit = 1'b1;
                end
            end
            ST_LEAD: begin
                if (bit_end) begin
                    if (cur_q.bcnt == LEAD_LAST) begin
                        nxt_d.st       = ST_DATA;
                        nxt_d.bcnt     = '0;
                        nxt_d.phase    = cur_q.phase ^ (bit_in ^ cur_q.last_bit);
                        nxt_d.last_bit = bit_in;
                        nxt_d.tick     = 1'b1;
                    end else begin
                        nxt_d.bcnt = cur_q.bcnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    if (frame_req) begin
                        nxt_d.phase    = cur_q.phase ^ (bit_in ^ cur_q.last_bit);
                        nxt_d.last_bit = bit_in;
                        nxt_d.tick     = 1'b1;
                    end else begin
                        nxt_d.st       = ST_TAIL;
                        nxt_d.bcnt     = '0;
                        nxt_d.phase    = cur_q.phase ^ ~cur_q.last_bit;
                        nxt_d.last_bit = 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (bit_end) begin
                    if (cur_q.bcnt == TAIL_LAST) nxt_d.st   = ST_IDLE;
                    else                         nxt_d.bcnt = cur_q.bcnt + 1'b1;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st       <= ST_IDLE;
            cur_q.rate     <= RATE_SLOWEST;
            cur_q.bcnt     <= '0;
            cur_q.phase    <= 1'b0;
            cur_q.last_bit <= 1'b1;
            cur_q.tick     <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign load_drive = run && (sc_wave ^ cur_q.phase);
    assign bit_tick   = cur_q.tick;

    // Observation points for the bound checker
    tx_state_e  mon_st;
    logic [1:0] mon_rate;
    logic       mon_phase;
    logic       mon_sc_last;
    assign mon_st      = cur_q.st;
    assign mon_rate    = cur_q.rate;
    assign mon_phase   = cur_q.phase;
    assign mon_sc_last = sc_last;

endmodule

// File: rtl/bpsk_load_mod_chk.sv
module bpsk_load_mod_chk
    import bpsk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       load_drive,
    input logic       bit_tick,
    input tx_state_e  st,
    input logic [1:0] rate_q,
    input logic       phase,
    input logic       sc_last
);
    // R6: the strobe never lasts more than one clock
    assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    // R4: no strobe outside data transmission (lead-in, tail, idle)
    assert_tick_in_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> (st == ST_DATA));

    // R5: phase only moves where a subcarrier cycle ends
    assert_phase_on_cycle_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase) |-> $past(sc_last));

    // R5: no drive pulse or gap of a single clock
    assert_no_short_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_drive) |=> load_drive);
    assert_no_short_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_drive) |=> !load_drive);

    // R8: captured rate holds for the whole frame
    assert_rate_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(rate_q));

endmodule

bind bpsk_load_mod bpsk_load_mod_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_drive (load_drive),
    .bit_tick   (bit_tick),
    .st         (mon_st),
    .rate_q     (mon_rate),
    .phase      (mon_phase),
    .sc_last    (mon_sc_last)
);

// File: tb/bpsk_load_mod_bench.sv
module bpsk_load_mod_bench;
    localparam int L = 2;
    localparam int T = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_req = 1'b0;
    logic       bit_in = 1'b1;
    logic [1:0] rate_sel = 2'd0;
    logic       load_drive, bit_tick;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5ns clk = ~clk;

    bpsk_load_mod #(.DIV(16), .SC_MAX(8), .LEAD_BITS(L), .TAIL_BITS(T)) u_bpsk_load_mod (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_req  (frame_req),
        .bit_in     (bit_in),
        .rate_sel   (rate_sel),
        .load_drive (load_drive),
        .bit_tick   (bit_tick)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int clocks_per_bit(input int rate);
        return 16 * (8 >> rate);
    endfunction

    function automatic logic exp_drive(input int k, input int p, input int n, input logic [7:0] bits);
        int seg = k / p;
        logic sc = ((k % 16) < 8);
        if (seg >= L + n + T) return 1'b0;
        if (seg >= L && seg < L + n) return sc ^ ~bits[seg - L];
        return sc;
    endfunction

    function automatic logic exp_tick(input int k, input int p, input int n);
        int seg = k / p;
        return (seg >= L && seg < L + n && (k % p) == 0);
    endfunction

    // One frame: rate, bit count, data (LSB first), whether rate_sel is disturbed
    task automatic run_frame(input int rate, input int n, input logic [7:0] bits, input bit disturb);
        int p = clocks_per_bit(rate);
        int total = (L + n + T) * p;
        @(negedge clk);
        rate_sel  = 2'(rate);
        bit_in    = bits[0];
        frame_req = 1'b1;
        @(posedge clk);
        for (int k = 0; k < total + 4; k++) begin
            int seg;
            string req;
            @(negedge clk);
            seg = k / p;
            if (seg < L)               req = "R4";
            else if (seg < L + n)      req = disturb ? "R8" : ((rate != 0) ? "R3" : "R5");
            else if (seg < L + n + T)  req = "R7";
            else                       req = "R1";
            if (k < 16 && seg < L) req = "R2";
            chk(req, "load_drive", load_drive, exp_drive(k, p, n, bits));
            chk((seg >= L && seg < L + n) ? "R6" : req, "bit_tick", bit_tick, exp_tick(k, p, n));
            if (exp_tick(k, p, n)) begin
                if (seg - L + 1 < n) bit_in = bits[seg - L + 1];
                else begin
                    frame_req = 1'b0;
                    bit_in    = 1'(($urandom() >> 3) & 1);
                end
            end
            if (disturb && (k % 37) == 5) rate_sel = 2'($urandom() & 3);
        end
    endtask

    initial begin
        #(10ns * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", "load_drive in reset", load_drive, 1'b0);
        chk("R1", "bit_tick in reset", bit_tick, 1'b0);
        rst_n = 1'b1;
        repeat (20) begin
            @(negedge clk);
            rate_sel = 2'($urandom() & 3);
            bit_in   = 1'($urandom() & 1);
            chk("R1", "idle load_drive", load_drive, 1'b0);
            chk("R1", "idle bit_tick", bit_tick, 1'b0);
        end
        // Directed corners
        run_frame(0, 8, 8'hFF, 1'b0);   // R5: no reversals at all
        run_frame(1, 8, 8'h55, 1'b0);   // R5: reversal every bit
        run_frame(2, 5, 8'h00, 1'b0);   // R7: tail reverses back from 0
        run_frame(3, 1, 8'h00, 1'b0);   // R3, R6: single bit, fastest rate
        run_frame(3, 8, 8'hA5, 1'b1);   // R8: rate disturbed mid-frame
        run_frame(0, 3, 8'h02, 1'b1);   // R8: slow rate disturbed
        // Seeded random frames
        for (int i = 0; i < 14; i++) begin
            int r = int'($urandom() % 4);
            int n = 1 + int'($urandom() % 8);
            logic [7:0] b = 8'($urandom());
            run_frame(r, n, b, 1'($urandom() & 1));
            repeat (int'($urandom() % 5)) @(negedge clk);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule